// File: doc/BRIEF.md
# Shared Global Memory Arbiter

This block lets several processor cores share one global address space. Each core has its own port with a four-phase request/acknowledge handshake. A core raises its request and waits for its acknowledge. While the acknowledge is high, the core may issue any number of single-word reads and writes. It then lowers the request, and the arbiter lowers the acknowledge. Only one port holds the grant at a time. The search for the next owner starts at the port after the one granted last, so a waiting core is served within one round.

The address space has two regions, split at the `IO_LIMIT` parameter. Addresses below `IO_LIMIT` go out on the peripheral interface, unchanged. Addresses at or above it select an internal synchronous RAM, at word offset `address - IO_LIMIT`. Both regions are reached through the same grant. For either region, read data comes back one clock after the access strobe. It arrives on a shared read bus and is marked by a one-cycle valid pulse on the owner's bit.

The controller has three states:
- SCAN: no acknowledge is high. A request found in round-robin order moves the controller to OWNED.
- OWNED: exactly one acknowledge is high. When the owner's request is seen low, the controller moves to RELEASE.
- RELEASE: no acknowledge is high and the search pointer advances. The controller always returns to SCAN on the next clock.

Top module: `gmem_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all acknowledges, all read-valid bits and `io_en` are low.
- R2: At most one bit of `core_ack` is high in any cycle. Bit i of each per-port vector belongs to port i.
- R3: An acknowledge rises only for a port whose request was high at the preceding clock edge. Once high, it stays high for as long as that request stays high, even when other ports are requesting.
- R4: The clock edge that samples the owner's request low lowers its acknowledge. The cycle after that still has no acknowledge high (RELEASE then SCAN), so no new grant appears in the cycle an acknowledge falls.
- R5: In SCAN, the port granted is the first requesting port found counting upward, with wrap-around, from the port after the previous owner. After reset the search starts at port 0.
- R6: An owner access with address below `IO_LIMIT` appears on `io_en`/`io_we`/`io_addr`/`io_wdata` in the same cycle, with the address unchanged. For an I/O read, `core_rdata` shows `io_rdata` in the following cycle.
- R7: An owner access with address at or above `IO_LIMIT` reaches the RAM word `address - IO_LIMIT` and does not assert `io_en`. A RAM read returns the last value written to that word.
- R8: A read strobe accepted at a clock edge gives, in the next cycle, `core_rvalid` equal to the owner's one-hot bit and the read data on `core_rdata`. The valid pulse lasts one cycle, and writes produce no valid pulse.
- R9: Access strobes from a port that does not hold the acknowledge are ignored. They cause no I/O access, no RAM write and no read-valid pulse.
- R10: When the controller is in SCAN and a single port requests, its acknowledge is high after the first clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | N_PORTS | Per-port request |
| core_ack | output | N_PORTS | Per-port acknowledge (grant) |
| core_en | input | N_PORTS | Per-port access strobe, one word per cycle |
| core_we | input | N_PORTS | Per-port write select (1 = write) |
| core_addr | input | N_PORTS*ADDR_W | Per-port word addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| core_wdata | input | N_PORTS*DATA_W | Per-port write data, port i at bits [i*DATA_W +: DATA_W] |
| core_rdata | output | DATA_W | Shared read data, qualified by core_rvalid |
| core_rvalid | output | N_PORTS | One-cycle read-valid pulse on the owner's bit |
| io_en | output | 1 | Peripheral access strobe |
| io_we | output | 1 | Peripheral write select |
| io_addr | output | ADDR_W | Peripheral address |
| io_wdata | output | DATA_W | Peripheral write data |
| io_rdata | input | DATA_W | Peripheral read data, valid the cycle after a read strobe |

## Verification
Two things can happen in the same cycle: the owner's acknowledge falls, and a new grant goes to another port that is already waiting. To provoke this, requests from other ports are left pending while the owner drops its request. The bench then expects two cycles with no acknowledge high, followed by a grant to the next port in round-robin order. A second overlap comes from strobing a non-owner port while the owner holds the grant. This is judged at the peripheral strobe and the read-valid outputs, and by reading the targeted RAM word back afterwards through the owner.

// File: rtl/gmarb_pkg.sv
`timescale 1ns/1ps
package gmarb_pkg;
    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_OWNED   = 2'd1,
        ST_RELEASE = 2'd2
    } arb_state_t;
endpackage

// File: rtl/gmarb_pick.sv
`timescale 1ns/1ps
// Round-robin search: first set request at or after the start index, with wrap-around.
module gmarb_pick #(
    parameter int N_PORTS = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_PORTS-1:0] req,
    input  logic [IDX_W-1:0]   start,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = start;
        for (int k = 0; k < N_PORTS; k++) begin
            int cand;
            cand = int'(start) + k;
            if (cand >= N_PORTS) cand = cand - N_PORTS;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/gmarb_route.sv
`timescale 1ns/1ps
// Selects the owner's access lines and decodes the region.
module gmarb_route #(
    parameter int N_PORTS  = 8,
    parameter int IDX_W    = 3,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int IO_LIMIT = 256
) (
    input  logic                       owned,
    input  logic [IDX_W-1:0]           owner,
    input  logic [N_PORTS-1:0]         core_en,
    input  logic [N_PORTS-1:0]         core_we,
    input  logic [N_PORTS*ADDR_W-1:0]  core_addr,
    input  logic [N_PORTS*DATA_W-1:0]  core_wdata,
    output logic                       sel_en,
    output logic                       sel_we,
    output logic [ADDR_W-1:0]          sel_addr,
    output logic [DATA_W-1:0]          sel_wdata,
    output logic                       is_io
);
    logic [ADDR_W-1:0] addr_a  [N_PORTS];
    logic [DATA_W-1:0] wdata_a [N_PORTS];

    for (genvar g = 0; g < N_PORTS; g++) begin : g_slice
        assign addr_a[g]  = core_addr[g*ADDR_W +: ADDR_W];
        assign wdata_a[g] = core_wdata[g*DATA_W +: DATA_W];
    end

    always_comb begin
        sel_en    = owned & core_en[owner];
        sel_we    = core_we[owner];
        sel_addr  = addr_a[owner];
        sel_wdata = wdata_a[owner];
        is_io     = {1'b0, sel_addr} < (ADDR_W+1)'(IO_LIMIT);
    end
endmodule

// File: rtl/gmarb_sram.sv
`timescale 1ns/1ps
// Single-port synchronous RAM with a registered read.
module gmarb_sram #(
    parameter int DEPTH  = 256,
    parameter int AW     = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/gmem_arbiter.sv
`timescale 1ns/1ps
module gmem_arbiter #(
    parameter int N_PORTS  = 8,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32,
    parameter int IO_LIMIT = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        core_req,
    output logic [N_PORTS-1:0]        core_ack,
    input  logic [N_PORTS-1:0]        core_en,
    input  logic [N_PORTS-1:0]        core_we,
    input  logic [N_PORTS*ADDR_W-1:0] core_addr,
    input  logic [N_PORTS*DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0]         core_rdata,
    output logic [N_PORTS-1:0]        core_rvalid,
    output logic                      io_en,
    output logic                      io_we,
    output logic [ADDR_W-1:0]         io_addr,
    output logic [DATA_W-1:0]         io_wdata,
    input  logic [DATA_W-1:0]         io_rdata
);
    import gmarb_pkg::*;

    localparam int IDX_W     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam int RAM_DEPTH = (1 << ADDR_W) - IO_LIMIT;
    localparam int RAM_AW    = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
    localparam logic [N_PORTS-1:0] ONE = N_PORTS'(1);

    arb_state_t        state_q, state_d;
    logic [IDX_W-1:0]  owner_q, owner_d;
    logic [IDX_W-1:0]  ptr_q, ptr_d;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic              owned;
    logic              sel_en, sel_we, is_io;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              ram_en;
    logic [RAM_AW-1:0] ram_addr;
    logic [DATA_W-1:0] ram_q;
    logic              rd_pend_q, rd_io_q;
    logic [IDX_W-1:0]  rd_port_q;

    gmarb_pick #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_pick (
        .req   (core_req),
        .start (ptr_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    gmarb_route #(
        .N_PORTS(N_PORTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .IO_LIMIT(IO_LIMIT)
    ) u_route (
        .owned      (owned),
        .owner      (owner_q),
        .core_en    (core_en),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .sel_en     (sel_en),
        .sel_we     (sel_we),
        .sel_addr   (sel_addr),
        .sel_wdata  (sel_wdata),
        .is_io      (is_io)
    );

    gmarb_sram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (sel_we),
        .addr  (ram_addr),
        .wdata (sel_wdata),
        .rdata (ram_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_SCAN;
            owner_q   <= '0;
            ptr_q     <= '0;
            rd_pend_q <= 1'b0;
            rd_io_q   <= 1'b0;
            rd_port_q <= '0;
        end else begin
            state_q   <= state_d;
            owner_q   <= owner_d;
            ptr_q     <= ptr_d;
            rd_pend_q <= sel_en & ~sel_we;
            rd_io_q   <= is_io;
            rd_port_q <= owner_q;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_SCAN: begin
                if (pick_found) begin
                    owner_d = pick_idx;
                    state_d = ST_OWNED;
                end
            end
            ST_OWNED: begin
                if (!core_req[owner_q]) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                ptr_d   = (owner_q == IDX_W'(N_PORTS-1)) ? '0 : owner_q + 1'b1;
                state_d = ST_SCAN;
            end
            default: state_d = ST_SCAN;
        endcase
    end

    // Outputs
    always_comb begin
        owned       = (state_q == ST_OWNED);
        core_ack    = owned ? (ONE << owner_q) : '0;
        io_en       = sel_en & is_io;
        io_we       = sel_we;
        io_addr     = sel_addr;
        io_wdata    = sel_wdata;
        ram_en      = sel_en & ~is_io;
        ram_addr    = RAM_AW'(sel_addr - ADDR_W'(IO_LIMIT));
        core_rvalid = rd_pend_q ? (ONE << rd_port_q) : '0;
        core_rdata  = rd_io_q ? io_rdata : ram_q;
    end
endmodule

// File: rtl/gmem_arbiter_chk.sv
`timescale 1ns/1ps
module gmem_arbiter_chk #(
    parameter int N_PORTS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PORTS-1:0] core_req,
    input logic [N_PORTS-1:0] core_ack,
    input logic [N_PORTS-1:0] core_rvalid,
    input logic               io_en
);
    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_ack));

    // R3
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack & ~$past(core_ack) & ~$past(core_req)) == '0);

    // R3
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(core_ack) & $past(core_req) & ~core_ack) == '0);

    // R4
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(core_ack)) && !(|core_ack)) |=> !(|core_ack));

    // R8
    rvalid_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rvalid & ~$past(core_ack)) == '0);

    // R9
    io_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> (|core_ack));
endmodule

bind gmem_arbiter gmem_arbiter_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_req    (core_req),
    .core_ack    (core_ack),
    .core_rvalid (core_rvalid),
    .io_en       (io_en)
);

// File: tb/gmem_arbiter_test.sv
`timescale 1ns/1ps
module gmem_arbiter_test;
    localparam int NP  = 8;
    localparam int AW  = 9;
    localparam int DW  = 32;
    localparam int LIM = 256;

    // {port[44:42], write[41], addr[40:32], data/expected[31:0]}
    localparam logic [44:0] VECS [8] = '{
        {3'd0, 1'b1, 9'h100, 32'hDEAD0001},
        {3'd0, 1'b0, 9'h100, 32'hDEAD0001},
        {3'd3, 1'b1, 9'h1FF, 32'hCAFE01FF},
        {3'd5, 1'b0, 9'h1FF, 32'hCAFE01FF},
        {3'd2, 1'b0, 9'h005, 32'hB0000005},
        {3'd7, 1'b1, 9'h0FF, 32'h12345678},
        {3'd1, 1'b1, 9'h100, 32'h0BADF00D},
        {3'd6, 1'b0, 9'h100, 32'h0BADF00D}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NP-1:0]    req = '0, en = '0, we = '0;
    logic [AW-1:0]    addr [NP];
    logic [DW-1:0]    wd   [NP];
    logic [NP*AW-1:0] addr_f;
    logic [NP*DW-1:0] wd_f;
    logic [NP-1:0]    ack, rvalid;
    logic [DW-1:0]    rdata, io_wdata;
    logic [DW-1:0]    io_rdata = '0;
    logic             io_en, io_we;
    logic [AW-1:0]    io_addr;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            addr_f[i*AW +: AW] = addr[i];
            wd_f[i*DW +: DW]   = wd[i];
        end
    end

    gmem_arbiter #(.N_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .IO_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .core_req(req), .core_ack(ack),
        .core_en(en), .core_we(we), .core_addr(addr_f), .core_wdata(wd_f),
        .core_rdata(rdata), .core_rvalid(rvalid),
        .io_en(io_en), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata)
    );

    // Peripheral model: registered read data, write log
    int            io_cnt = 0;
    logic [AW-1:0] io_last_a = '0;
    logic [DW-1:0] io_last_d = '0;
    function automatic logic [DW-1:0] io_pattern(logic [AW-1:0] a);
        return 32'hB000_0000 | {23'd0, a};
    endfunction
    always @(posedge clk) begin
        if (io_en) begin
            io_cnt <= io_cnt + 1;
            if (io_we) begin
                io_last_a <= io_addr;
                io_last_d <= io_wdata;
            end else begin
                io_rdata <= io_pattern(io_addr);
            end
        end
    end

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // From a negedge: raise request, wait until granted
    task automatic acquire(input int p, output int lat);
        req[p] = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack[p] && lat < 30);
    endtask

    // From a negedge while owning: one access, result sampled next negedge
    task automatic access(input int p, input bit w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [NP-1:0] rv,
                          output logic [DW-1:0] rd, output logic [NP-1:0] rv_after);
        en[p] = 1'b1; we[p] = w; addr[p] = a; wd[p] = d;
        @(negedge clk);
        rv = rvalid; rd = rdata;
        en[p] = 1'b0; we[p] = 1'b0;
        @(negedge clk);
        rv_after = rvalid;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat, cnt0;
        logic [NP-1:0] rv, rv2;
        logic [DW-1:0] rd;
        for (int i = 0; i < NP; i++) begin addr[i] = '0; wd[i] = '0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(ack == '0 && rvalid == '0 && !io_en, "R1 in reset", {ack, rvalid, 7'd0, io_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == '0 && rvalid == '0, "R1 after reset", {ack, rvalid}, 0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            int p;
            bit w;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            p = int'(VECS[i][44:42]); w = VECS[i][41];
            a = VECS[i][40:32];       d = VECS[i][31:0];
            cnt0 = io_cnt;
            acquire(p, lat);
            chk(lat == 1, "R10 grant latency", lat, 1);
            chk(ack == (NP'(1) << p), "R2 one-hot owner", ack, NP'(1) << p);
            access(p, w, a, d, rv, rd, rv2);
            if (w) begin
                chk(rv == '0, "R8 no valid on write", rv, 0);
                if (a < LIM) begin
                    chk(io_cnt == cnt0 + 1 && io_last_a == a, "R6 io write addr", io_last_a, a);
                    chk(io_last_d == d, "R6 io write data", io_last_d, d);
                end else begin
                    chk(io_cnt == cnt0, "R7 ram write not on io", io_cnt, cnt0);
                end
            end else begin
                chk(rv == (NP'(1) << p), "R8 valid on owner", rv, NP'(1) << p);
                chk(rv2 == '0, "R8 valid one cycle", rv2, 0);
                if (a < LIM) chk(rd == d, "R6 io read data", rd, d);
                else         chk(rd == d, "R7 ram read data", rd, d);
            end
            req[p] = 1'b0;
            @(negedge clk);
            chk(ack == '0, "R4 ack drops", ack, 0);
            @(negedge clk);
        end

        // R5/R3/R4: contention, last owner 6 so search starts at 7
        req[0] = 1'b1; req[2] = 1'b1; req[7] = 1'b1;
        @(negedge clk);
        chk(ack == 8'h80, "R5 start after last owner", ack, 8'h80);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(ack == 8'h80, "R3 grant held", ack, 8'h80);
        end
        req[7] = 1'b0;
        @(negedge clk);
        chk(ack == '0, "R4 release", ack, 0);
        @(negedge clk);
        chk(ack == '0, "R4 no grant in gap", ack, 0);
        @(negedge clk);
        chk(ack == 8'h01, "R5 wrap to port 0", ack, 8'h01);

        // R9: non-owner strobes ignored
        access(0, 1'b1, 9'h180, 32'h11112222, rv, rd, rv2);
        cnt0 = io_cnt;
        en[3] = 1'b1; we[3] = 1'b1; addr[3] = 9'h010; wd[3] = 32'hFFFFFFFF;
        @(negedge clk);
        chk(io_cnt == cnt0, "R9 no io from non-owner", io_cnt, cnt0);
        addr[3] = 9'h180;
        @(negedge clk);
        we[3] = 1'b0;
        @(negedge clk);
        en[3] = 1'b0;
        @(negedge clk);
        chk(rvalid == '0, "R9 no valid for non-owner", rvalid, 0);
        chk(ack == 8'h01, "R3 owner kept during strobes", ack, 8'h01);
        access(0, 1'b0, 9'h180, 32'h0, rv, rd, rv2);
        chk(rd == 32'h11112222, "R9 ram not written by non-owner", rd, 32'h11112222);

        req[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk(ack == '0, "R4 gap before port 2", ack, 0);
        @(negedge clk);
        chk(ack == 8'h04, "R5 next waiting port", ack, 8'h04);
        req[2] = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset while owned
        acquire(4, lat);
        rst_n = 1'b0;
        #1;
        chk(ack == '0, "R1 reset clears grant", ack, 0);
        @(negedge clk);
        req[4] = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ack == '0 && rvalid == '0, "R1 idle after reset", {ack, rvalid}, 0);

        finish_run();
    end
endmodule